// File: doc/BRIEF.md
# USB IN Endpoint Transmit Scheduler

This block answers IN tokens for a single USB endpoint whose transmit data sits in a circular buffer of 16-bit words in shared memory. A producing processor fills the buffer and publishes its write offset. The scheduler owns the read offset. On each token it works out how many words are waiting and chooses between sending a packet and answering NAK. When it sends, it drives the word count and start address of the data phase and issues one memory read strobe per word, walking the buffer with wrap-around.

A full packet, meaning at least the maximum packet size is waiting, always goes out at once. A short packet is held back until a programmable number of NAKs, from 0 to 15, has been returned for it. This lets the host side decide how soon a partially filled transfer gets retired. The committed read offset moves only when the host acknowledges. After a timeout the same words are offered again on the next token.

The control is a four-state machine. The states are `ST_IDLE` (wait for a token), `ST_EVAL` (measure the fill level and decide), `ST_READ` (one memory read per word) and `ST_WAIT` (wait for the handshake). The transitions are: IDLE→EVAL on a token. EVAL→READ when sending, and EVAL→IDLE on a NAK. READ→READ while words remain, and READ→WAIT after the last word. WAIT→IDLE on an ACK, which commits the offset, or on a timeout, which discards the attempt.

Top module: `usb_in_sched`

## Requirements
- R1: After reset, `rd_off` is 0, and `rsp_valid` and `mem_rd` are low.
- R2: A token sampled at clock edge k gives a one-cycle `rsp_valid` after edge k+1. If the fill level is at least `max_pkt`, `rsp_send`=1, `pkt_words`=`max_pkt` and `pkt_start`=`rd_off`.
- R3: With a fill level of 0, the answer is NAK (`rsp_send`=0, `pkt_words`=0), and the short-packet NAK count does not advance.
- R4: With a fill level between 1 and `max_pkt`-1, the answer is NAK while the count of short NAKs is below `nak_lim`, and each such NAK raises the count by one. Once the count reaches `nak_lim`, all waiting words are sent. A limit of 0 sends at once.
- R5: The short NAK count returns to 0 whenever a packet is sent and whenever `nak_lim` changes value.
- R6: For a send, `mem_rd` is high for exactly `pkt_words` consecutive cycles, starting in the `rsp_valid` cycle. `mem_addr` starts at `pkt_start` and steps by one, going from `buf_size`-1 to 0.
- R7: A `host_ack` sampled while waiting for the handshake sets `rd_off` to (`pkt_start`+`pkt_words`) mod `buf_size`, visible after that edge. `rd_off` changes at no other time.
- R8: A `host_tmo` without `host_ack` leaves `rd_off` unchanged, so the next token offers the same start address.
- R9: The fill level is `wr_off`-`rd_off` when `wr_off`≥`rd_off`, and `buf_size`-`rd_off`+`wr_off` otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tok_in | input | 1 | IN token strobe, one cycle |
| wr_off | input | AW | Producer write offset |
| buf_size | input | AW+1 | Buffer length in words |
| max_pkt | input | AW+1 | Maximum packet size in words |
| nak_lim | input | 4 | NAKs to return before a short packet goes out |
| host_ack | input | 1 | Host acknowledged the data phase |
| host_tmo | input | 1 | Handshake timed out |
| rsp_valid | output | 1 | Decision strobe |
| rsp_send | output | 1 | 1 = send data, 0 = NAK |
| pkt_words | output | AW+1 | Words in the data phase |
| pkt_start | output | AW | First word address of the data phase |
| mem_rd | output | 1 | Buffer read strobe |
| mem_addr | output | AW | Buffer read address |
| rd_off | output | AW | Committed read offset |

## Verification
The assertions assume a stable configuration: `buf_size` of at least 2, `max_pkt` between 1 and `buf_size`-1, `wr_off` below `buf_size`, and a producer that never fills more than `buf_size`-1 words. They also assume tokens arrive only while the block is idle, and handshakes only while it waits. The bench sets the size and packet limit once and derives each new write offset from the modelled read offset plus a random fill below the buffer length. It raises tokens only after the previous exchange has finished, and pulses the handshake only after the last read strobe.

// File: rtl/usb_in_pkg.sv
package usb_in_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_EVAL = 2'd1,
        ST_READ = 2'd2,
        ST_WAIT = 2'd3
    } sched_state_t;
endpackage

// File: rtl/ring_span.sv
// Words waiting between read and write offsets of a circular buffer.
module ring_span #(
    parameter int AW = 8
) (
    input  logic [AW-1:0] wr_i,
    input  logic [AW-1:0] rd_i,
    input  logic [AW:0]   size_i,
    output logic [AW:0]   span_o
);
    logic [AW:0] wr_x;
    logic [AW:0] rd_x;

    assign wr_x = {1'b0, wr_i};
    assign rd_x = {1'b0, rd_i};

    always_comb begin
        if (wr_x >= rd_x) begin
            span_o = wr_x - rd_x;
        end else begin
            span_o = size_i - rd_x + wr_x;
        end
    end
endmodule

// File: rtl/ring_step.sv
// Advance an offset by a count, modulo the buffer length.
module ring_step #(
    parameter int AW = 8
) (
    input  logic [AW-1:0] base_i,
    input  logic [AW:0]   inc_i,
    input  logic [AW:0]   size_i,
    output logic [AW-1:0] next_o
);
    localparam int SW = AW + 2;

    logic [SW-1:0] sum_w;
    logic [SW-1:0] lim_w;
    logic [SW-1:0] res_w;
    logic [1:0]    hi_unused;

    assign sum_w = {2'b00, base_i} + {1'b0, inc_i};
    assign lim_w = {1'b0, size_i};
    assign res_w = (sum_w >= lim_w) ? (sum_w - lim_w) : sum_w;
    assign next_o = res_w[AW-1:0];
    assign hi_unused = res_w[SW-1:AW];
endmodule

// File: rtl/nak_gate.sv
// Counts NAKs given to a short packet and says when the limit is reached.
module nak_gate #(
    parameter int CW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [CW-1:0] lim_i,
    input  logic          bump_i,
    input  logic          sent_i,
    output logic          reached_o
);
    localparam logic [CW-1:0] CNT_MAX = {CW{1'b1}};

    logic [CW-1:0] cnt_q;
    logic [CW-1:0] lim_q;
    logic          lim_moved;

    assign lim_moved = (lim_i != lim_q);
    assign reached_o = (cnt_q >= lim_i);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            lim_q <= '0;
        end else begin
            lim_q <= lim_i;
            if (sent_i || lim_moved) begin
                cnt_q <= '0;
            end else if (bump_i && (cnt_q != CNT_MAX)) begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end
endmodule

// File: rtl/usb_in_sched.sv
module usb_in_sched
    import usb_in_pkg::*;
#(
    parameter int AW = 8,
    parameter int CW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tok_in,
    input  logic [AW-1:0] wr_off,
    input  logic [AW:0]   buf_size,
    input  logic [AW:0]   max_pkt,
    input  logic [CW-1:0] nak_lim,
    input  logic          host_ack,
    input  logic          host_tmo,
    output logic          rsp_valid,
    output logic          rsp_send,
    output logic [AW:0]   pkt_words,
    output logic [AW-1:0] pkt_start,
    output logic          mem_rd,
    output logic [AW-1:0] mem_addr,
    output logic [AW-1:0] rd_off
);
    localparam logic [AW:0] ONE_W = {{AW{1'b0}}, 1'b1};

    sched_state_t state_q, state_d;

    logic [AW-1:0] rd_off_q;
    logic [AW-1:0] cur_q;
    logic [AW-1:0] end_q;
    logic [AW:0]   left_q;

    logic [AW:0]   span;
    logic [AW-1:0] end_off;
    logic [AW-1:0] cur_next;
    logic          short_ok;

    logic          is_eval;
    logic          full_pkt;
    logic          empty;
    logic          send_now;
    logic [AW:0]   words_now;
    logic          nak_bump;
    logic          nak_sent;

    ring_span #(.AW(AW)) u_span (
        .wr_i   (wr_off),
        .rd_i   (rd_off_q),
        .size_i (buf_size),
        .span_o (span)
    );

    ring_step #(.AW(AW)) u_end (
        .base_i (rd_off_q),
        .inc_i  (words_now),
        .size_i (buf_size),
        .next_o (end_off)
    );

    ring_step #(.AW(AW)) u_cur (
        .base_i (cur_q),
        .inc_i  (ONE_W),
        .size_i (buf_size),
        .next_o (cur_next)
    );

    nak_gate #(.CW(CW)) u_nak (
        .clk       (clk),
        .rst_n     (rst_n),
        .lim_i     (nak_lim),
        .bump_i    (nak_bump),
        .sent_i    (nak_sent),
        .reached_o (short_ok)
    );

    // Decision made while evaluating a token.
    always_comb begin
        is_eval   = (state_q == ST_EVAL);
        full_pkt  = (span >= max_pkt);
        empty     = (span == '0);
        send_now  = full_pkt || (!empty && short_ok);
        words_now = full_pkt ? max_pkt : span;
        nak_bump  = is_eval && !empty && !full_pkt && !short_ok;
        nak_sent  = is_eval && send_now;
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Transitions.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (tok_in) state_d = ST_EVAL;
            ST_EVAL: state_d = send_now ? ST_READ : ST_IDLE;
            ST_READ: if (left_q == ONE_W) state_d = ST_WAIT;
            ST_WAIT: if (host_ack || host_tmo) state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // Outputs and datapath registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_send  <= 1'b0;
            pkt_words <= '0;
            pkt_start <= '0;
            rd_off_q  <= '0;
            cur_q     <= '0;
            end_q     <= '0;
            left_q    <= '0;
        end else begin
            rsp_valid <= 1'b0;
            unique case (state_q)
                ST_IDLE: ;
                ST_EVAL: begin
                    rsp_valid <= 1'b1;
                    rsp_send  <= send_now;
                    pkt_words <= send_now ? words_now : '0;
                    pkt_start <= rd_off_q;
                    cur_q     <= rd_off_q;
                    left_q    <= send_now ? words_now : '0;
                    end_q     <= end_off;
                end
                ST_READ: begin
                    cur_q  <= cur_next;
                    left_q <= left_q - ONE_W;
                end
                ST_WAIT: begin
                    if (host_ack) rd_off_q <= end_q;
                end
                default: ;
            endcase
        end
    end

    assign mem_rd   = (state_q == ST_READ);
    assign mem_addr = cur_q;
    assign rd_off   = rd_off_q;
endmodule

// File: rtl/usb_in_sched_chk.sv
module usb_in_sched_chk #(
    parameter int AW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          tok_in,
    input logic [AW:0]   buf_size,
    input logic [AW:0]   max_pkt,
    input logic          host_ack,
    input logic          host_tmo,
    input logic          rsp_valid,
    input logic          rsp_send,
    input logic [AW:0]   pkt_words,
    input logic          mem_rd,
    input logic [AW-1:0] mem_addr,
    input logic [AW-1:0] rd_off
);
    function automatic logic [AW-1:0] step1(input logic [AW-1:0] a, input logic [AW:0] sz);
        logic [AW:0] n;
        n = {1'b0, a} + 1'b1;
        return (n == sz) ? '0 : n[AW-1:0];
    endfunction

    // R2: a decision comes two edges after a token
    a_r2_rsp_after_token: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $past(tok_in, 2));

    // R2: a packet never exceeds the maximum size
    a_r2_words_capped: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_send) |-> (pkt_words <= max_pkt));

    // R3: nothing is sent from an empty buffer
    a_r3_no_empty_send: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_send) |-> (pkt_words != '0));

    // R6: reads start with the decision of a send
    a_r6_read_with_send: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (mem_rd == rsp_send));

    // R6: addresses stay inside the buffer
    a_r6_addr_in_buf: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd |-> ({1'b0, mem_addr} < buf_size));

    // R6: consecutive reads step by one with wrap
    a_r6_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd && $past(mem_rd)) |-> (mem_addr == step1($past(mem_addr), buf_size)));

    // R7: the read offset moves only on an acknowledge
    a_r7_off_on_ack: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_off != $past(rd_off)) |-> $past(host_ack));

    // R8: a timeout alone keeps the read offset
    a_r8_tmo_holds: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(host_tmo) && !$past(host_ack)) |-> $stable(rd_off));
endmodule

bind usb_in_sched usb_in_sched_chk #(.AW(AW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .tok_in    (tok_in),
    .buf_size  (buf_size),
    .max_pkt   (max_pkt),
    .host_ack  (host_ack),
    .host_tmo  (host_tmo),
    .rsp_valid (rsp_valid),
    .rsp_send  (rsp_send),
    .pkt_words (pkt_words),
    .mem_rd    (mem_rd),
    .mem_addr  (mem_addr),
    .rd_off    (rd_off)
);

// File: tb/tb_usb_in_sched.sv
module tb_usb_in_sched;
    localparam int AW = 8;
    localparam int SIZE = 40;
    localparam int MAXP = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          tok_in = 1'b0;
    logic [AW-1:0] wr_off = '0;
    logic [AW:0]   buf_size = SIZE;
    logic [AW:0]   max_pkt = MAXP;
    logic [3:0]    nak_lim = '0;
    logic          host_ack = 1'b0;
    logic          host_tmo = 1'b0;
    logic          rsp_valid, rsp_send, mem_rd;
    logic [AW:0]   pkt_words;
    logic [AW-1:0] pkt_start, mem_addr, rd_off;

    int total = 0;
    int bad = 0;
    bit done = 0;
    int m_rd = 0;
    int m_cnt = 0;

    usb_in_sched #(.AW(AW)) dut (.*);

    always #5 clk = ~clk;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
        end
    endtask

    function automatic int fill(input int wr, input int rd);
        return (wr >= rd) ? wr - rd : SIZE - rd + wr;
    endfunction

    task automatic set_lim(input int v);
        @(negedge clk);
        if (v != int'(nak_lim)) m_cnt = 0;   // R5 model
        nak_lim = 4'(v);
    endtask

    task automatic set_wr(input int v);
        @(negedge clk);
        wr_off = AW'(v);
    endtask

    // One token exchange; ack=1 answers ACK, 0 lets it time out.
    task automatic token(input bit ack);
        int av, words, cur;
        bit snd;
        string tg;
        av = fill(int'(wr_off), m_rd);
        tg = (int'(wr_off) < m_rd) ? "R9" : "R2";
        if (av >= MAXP) begin snd = 1; words = MAXP; end
        else if (av == 0) begin snd = 0; words = 0; end
        else if (m_cnt >= int'(nak_lim)) begin snd = 1; words = av; end
        else begin snd = 0; words = 0; m_cnt++; end
        if (snd) m_cnt = 0;
        @(negedge clk) tok_in = 1'b1;
        @(negedge clk) tok_in = 1'b0;
        check(rsp_valid == 1'b0, "R2 early rsp", int'(rsp_valid), 0);
        @(negedge clk);
        check(rsp_valid == 1'b1, "R2 rsp_valid", int'(rsp_valid), 1);
        check(rsp_send == snd, av == 0 ? "R3 send" : (av < MAXP ? "R4 send" : tg),
              int'(rsp_send), int'(snd));
        check(int'(pkt_words) == words, av < MAXP ? "R4 words" : tg, int'(pkt_words), words);
        if (snd) begin
            check(int'(pkt_start) == m_rd, "R8 start", int'(pkt_start), m_rd);
            cur = m_rd;
            for (int i = 0; i < words; i++) begin
                if (i > 0) @(negedge clk);
                check(mem_rd == 1'b1, "R6 mem_rd", int'(mem_rd), 1);
                check(int'(mem_addr) == cur, "R6 addr", int'(mem_addr), cur);
                cur = (cur + 1) % SIZE;
            end
            @(negedge clk);
            check(mem_rd == 1'b0, "R6 read end", int'(mem_rd), 0);
            if (ack) host_ack = 1'b1; else host_tmo = 1'b1;
            @(negedge clk);
            host_ack = 1'b0;
            host_tmo = 1'b0;
            if (ack) m_rd = (m_rd + words) % SIZE;
            check(int'(rd_off) == m_rd, ack ? "R7 rd_off" : "R8 rd_off", int'(rd_off), m_rd);
        end else begin
            check(mem_rd == 1'b0, "R3 no read", int'(mem_rd), 0);
            check(int'(rd_off) == m_rd, "R3 rd_off", int'(rd_off), m_rd);
        end
    endtask

    initial begin
        int seed;
        seed = 32'h5eed_1d;
        void'($urandom(seed));
        repeat (3) @(negedge clk);
        check(rsp_valid == 1'b0, "R1 rsp_valid", int'(rsp_valid), 0);
        check(mem_rd == 1'b0, "R1 mem_rd", int'(mem_rd), 0);
        check(rd_off == '0, "R1 rd_off", int'(rd_off), 0);
        rst_n = 1'b1;

        // R3: empty buffer NAKs without moving the count
        set_lim(2);
        repeat (3) token(1);
        // R4: short packet after two NAKs
        set_wr(3);
        repeat (3) token(1);
        // R2 full packet, R8 timeout then resend
        set_wr(3 + 20);
        token(0);
        token(1);
        // R5: limit change clears the count
        set_wr(m_rd + 2);
        set_lim(3);
        token(1);
        set_lim(1);
        token(1);
        token(1);
        // R4: limit 0 sends at once
        set_lim(0);
        set_wr((m_rd + 1) % SIZE);
        token(1);

        for (int n = 0; n < 400; n++) begin
            if ($urandom_range(7) == 0) set_lim($urandom_range(4));
            if ($urandom_range(2) != 0)
                set_wr((m_rd + $urandom_range(SIZE - 1)) % SIZE);
            token($urandom_range(3) != 0);
        end
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog act=%0d exp=%0d", 0, 1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule